// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Selector

This block picks one of two clock inputs under a level select signal and produces one output clock with no runt pulse and no shortened phase. It suits clock-redundancy schemes in which one reference may fail. An external stopped-clock detector supplies one bad flag per input. The handover is then allowed to finish even when the clock being left has stopped and can no longer clock its own logic.

Each input has its own lane. The lane brings the select and the other lane's status into its own clock domain through synchronizer chains. It counts a hold-off of its own clock cycles. It opens or closes its gate only on its own falling edge. A bad flag acts as an asynchronous clear on its lane, so a dead lane closes at once and reads as closed to the other lane. After a clear, the lane starts its select and hold-off sequence again from the beginning.

Top module: `glitchfree_clk_sel`

## Requirements
- R1: With `sel_i` = 0 the output follows `clk0_i`; with `sel_i` = 1 it follows `clk1_i`. Following means it is high in each high phase and low in each low phase of that clock.
- R2: While `rst_ni` is low the output is low. After reset is released the output stays low for at least one full period of the selected clock before its first rising edge.
- R3: No high phase of the output is shorter than the high phase of the clock that produced it, and no low phase is shorter than the shortest half period of either input. This holds across every handover.
- R4: When the select changes with both clocks running, the old clock's current cycle completes and the output goes low. The output then stays low for at least one full period of the new clock and then follows the new clock.
- R5: The newly selected lane opens only after the old lane's gate is closed or the old input's bad flag is set.
- R6: While the selected input's bad flag is high, the output is low. After the flag clears, the output stays low for at least one full period of that clock and then follows it again.
- R7: If the select moves to a running clock while the old input is flagged bad, the output stays low for at least one full period of the new clock and then follows it.
- R8: If the select changes after the old clock has stopped but before its bad flag rises, the output makes no rising edge until the flag rises. After that it follows the new clock.
- R9: A bad flag on the input that is not selected has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | First clock input |
| clk1_i | input | 1 | Second clock input |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Level select: 0 picks `clk0_i`, 1 picks `clk1_i` |
| dead0_i | input | 1 | Stopped-clock flag for `clk0_i`, active high |
| dead1_i | input | 1 | Stopped-clock flag for `clk1_i`, active high |
| clk_o | output | 1 | Selected, gated output clock |

## Verification
The hardest case to reach is the window in which the old clock has frozen with its gate still open but its bad flag has not yet risen. In that window the new lane must wait indefinitely. The bench reaches it by stopping the old clock's generator just after a falling edge, so the gate stays open with the clock low. It then flips the select and holds the flag low for a long window while it counts rising edges on the output. The flag is raised only after that window. The bench drives the stuck-high variant the same way: it stops a generator just after a rising edge and checks that the flag alone pulls the output low.

// File: rtl/ckmux_pkg.sv
`timescale 1ns/1ps
package ckmux_pkg;

    // Width of the hold-off counter in each lane.
    localparam int unsigned CNT_W = 4;

    typedef logic [CNT_W-1:0] hold_cnt_t;

    // Posedge-domain control state of one lane.
    typedef struct packed {
        hold_cnt_t cnt;   // hold-off cycles seen with the peer closed
        logic      go;    // lane is cleared to open its gate
    } lane_ctl_t;

    localparam lane_ctl_t LANE_CTL_RST = '{cnt: '0, go: 1'b0};

endpackage

// File: rtl/ckmux_sync.sv
`timescale 1ns/1ps
// N-stage synchronizer with asynchronous clear.
module ckmux_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
        q_o  = sh_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end
endmodule

// File: rtl/ckmux_lane.sv
`timescale 1ns/1ps
// One input lane: select sync, peer-status sync, hold-off counter and a
// falling-edge gate.
module ckmux_lane
    import ckmux_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 2
) (
    input  logic clk_i,
    input  logic rst_ni,      // global reset combined with this input's bad flag
    input  logic want_i,      // this lane is the selected one (asynchronous)
    input  logic peer_off_i,  // other lane is closed or dead (asynchronous)
    output logic en_o,
    output logic gclk_o
);
    localparam hold_cnt_t HOLD_LAST = hold_cnt_t'(HOLD_CYC);

    logic      want_s, poff_s;
    lane_ctl_t ctl_d, ctl_q;
    logic      en_d, en_q;

    ckmux_sync #(.STAGES(SYNC_STAGES)) i_want_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (want_i),
        .q_o    (want_s)
    );

    ckmux_sync #(.STAGES(SYNC_STAGES)) i_peer_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (peer_off_i),
        .q_o    (poff_s)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!want_s) begin
            ctl_d = LANE_CTL_RST;
        end else if (!ctl_q.go) begin
            if (!poff_s) begin
                ctl_d.cnt = '0;
            end else if (ctl_q.cnt == HOLD_LAST) begin
                ctl_d.go = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
        en_d = ctl_q.go;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= LANE_CTL_RST;
        else         ctl_q <= ctl_d;
    end

    // Gate changes only while the clock is low.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_d;
    end

    assign en_o   = en_q;
    assign gclk_o = clk_i & en_q;

    // R5: the lane is cleared to open only after it saw the peer closed.
    a_r5_go_waits_peer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctl_q.go) |-> $past(poff_s));

    // R4: the hold-off counter never runs past its limit.
    a_r4_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_q.cnt <= HOLD_LAST);

    // R3: an open gate always has the posedge-side clearance behind it.
    a_r3_gate_has_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q |-> ctl_q.go);

    // R4: a deselected lane withdraws its clearance on the next edge.
    a_r4_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !want_s |=> !ctl_q.go);
endmodule

// File: rtl/glitchfree_clk_sel.sv
`timescale 1ns/1ps
module glitchfree_clk_sel #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYC    = 2
) (
    input  logic clk0_i,
    input  logic clk1_i,
    input  logic rst_ni,
    input  logic sel_i,
    input  logic dead0_i,
    input  logic dead1_i,
    output logic clk_o
);
    localparam int unsigned NLANE = 2;

    logic [NLANE-1:0] clk_in, dead, en, gclk;

    assign clk_in = {clk1_i, clk0_i};
    assign dead   = {dead1_i, dead0_i};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic lane_rst_n, want, peer_off;

        assign lane_rst_n = rst_ni & ~dead[g];
        assign want       = (sel_i == 1'(g));
        assign peer_off   = ~en[NLANE-1-g] | dead[NLANE-1-g];

        ckmux_lane #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_CYC    (HOLD_CYC)
        ) i_lane (
            .clk_i      (clk_in[g]),
            .rst_ni     (lane_rst_n),
            .want_i     (want),
            .peer_off_i (peer_off),
            .en_o       (en[g]),
            .gclk_o     (gclk[g])
        );
    end

    assign clk_o = |gclk;

    // R5: the two gates are never open together.
    always_comb begin
        if (rst_ni) begin
            a_r5_one_gate: assert (!(en[0] && en[1]));
        end
    end

    // R6: a flagged first input with the second gate closed leaves the output low.
    a_r6_dead_is_quiet: assert property (@(posedge clk1_i) disable iff (!rst_ni)
        (dead0_i && !en[1]) |-> !clk_o);
endmodule

// File: tb/test_glitchfree_clk_sel.sv
`timescale 1ns/1ps
module test_glitchfree_clk_sel;
    localparam int TCLK0_NS = 10;
    localparam int TCLK1_NS = 14;

    logic clk0 = 1'b0, clk1 = 1'b0;
    logic run0 = 1'b1, run1 = 1'b1;
    logic rst_n = 1'b0, sel = 1'b0, dead0 = 1'b0, dead1 = 1'b0;
    logic clk_o;

    int n_vec = 0, n_bad = 0;

    always #(TCLK0_NS / 2) if (run0) clk0 = ~clk0;
    always #(TCLK1_NS / 2) if (run1) clk1 = ~clk1;

    glitchfree_clk_sel i_glitchfree_clk_sel (
        .clk0_i  (clk0),
        .clk1_i  (clk1),
        .rst_ni  (rst_n),
        .sel_i   (sel),
        .dead0_i (dead0),
        .dead1_i (dead1),
        .clk_o   (clk_o)
    );

    // Output edge monitor: pulse widths and low gap before a first rise.
    real t_rise = 0.0, t_fall = 0.0, t_ref = 0.0, gap = 0.0;
    bit  seen_rise = 0, seen_fall = 0, arm = 0, got = 0;
    int  rises = 0, short_hi = 0, short_lo = 0;

    always @(posedge clk_o) begin
        rises++;
        if (seen_fall && ($realtime - t_fall) < 4.99) short_lo++;
        t_rise    = $realtime;
        seen_rise = 1;
        if (arm) begin
            gap = $realtime - ((t_fall > t_ref) ? t_fall : t_ref);
            arm = 0;
            got = 1;
        end
    end

    always @(negedge clk_o) begin
        if (seen_rise) begin
            if (($realtime - t_rise) < 4.99) short_hi++;
            t_fall    = $realtime;
            seen_fall = 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic real qtr(input int src);
        return ((src == 0) ? TCLK0_NS : TCLK1_NS) / 4.0;
    endfunction

    task automatic follow(input int src, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            if (src == 0) @(posedge clk0); else @(posedge clk1);
            #(qtr(src));
            check(clk_o === 1'b1, req, "output in high phase", int'(clk_o), 1);
            if (src == 0) @(negedge clk0); else @(negedge clk1);
            #(qtr(src));
            check(clk_o === 1'b0, req, "output in low phase", int'(clk_o), 0);
        end
    endtask

    task automatic arm_gap(input real ref_t);
        got   = 0;
        t_ref = ref_t;
        arm   = 1;
    endtask

    task automatic gap_check(input string req, input int tnew);
        check(got && gap >= tnew, req, "low gap before first rise (ps, min)",
              int'(gap * 1000.0), tnew * 1000);
    endtask

    // R2 and R1: reset and first lock onto input 0.
    task automatic t_reset;
        rst_n = 1'b0;
        sel   = 1'b0;
        for (int i = 0; i < 3; i++) begin
            repeat (2) @(posedge clk0);
            #1 check(clk_o === 1'b0, "R2", "output during reset", int'(clk_o), 0);
        end
        @(negedge clk0);
        arm_gap($realtime);
        rst_n = 1'b1;
        repeat (20) @(posedge clk0);
        gap_check("R2", TCLK0_NS);
        follow(0, 6, "R1");
    endtask

    // R4 and R1: handover with both clocks running.
    task automatic t_switch(input int to);
        int told = (to == 1) ? TCLK0_NS : TCLK1_NS;
        int tnew = (to == 1) ? TCLK1_NS : TCLK0_NS;
        sel = 1'(to);
        #(6 * told);
        arm_gap(0.0);
        #(20 * tnew);
        gap_check("R4", tnew);
        follow(to, 6, "R1");
    endtask

    // R6: selected input stuck high, then flagged, then restored.
    task automatic t_dead_selected;
        @(posedge clk0);
        #1 run0 = 1'b0;
        #30 dead0 = 1'b1;
        #1 check(clk_o === 1'b0, "R6", "output right after flag", int'(clk_o), 0);
        for (int i = 0; i < 5; i++) begin
            #20 check(clk_o === 1'b0, "R6", "output while flagged", int'(clk_o), 0);
        end
        run0 = 1'b1;
        #(8 * TCLK0_NS);
        arm_gap($realtime);
        dead0 = 1'b0;
        #(20 * TCLK0_NS);
        gap_check("R6", TCLK0_NS);
        follow(0, 6, "R6");
    endtask

    // R7: move to input 1 while input 0 is stopped and flagged.
    task automatic t_old_dead_switch;
        @(negedge clk0);
        #1 run0 = 1'b0;
        #40 dead0 = 1'b1;
        #20;
        arm_gap($realtime);
        sel = 1'b1;
        #(20 * TCLK1_NS);
        gap_check("R7", TCLK1_NS);
        follow(1, 6, "R7");
        run0 = 1'b1;
        #(8 * TCLK0_NS);
        dead0 = 1'b0;
        #(10 * TCLK0_NS);
        follow(1, 2, "R9");
    endtask

    // R8 and R5: select change while input 1 is stopped but not yet flagged.
    task automatic t_switch_before_flag;
        int r0;
        @(negedge clk1);
        #1 run1 = 1'b0;
        #5 sel = 1'b0;
        r0 = rises;
        #200;
        check(rises == r0, "R8", "rising edges before flag", rises - r0, 0);
        check(clk_o === 1'b0, "R5", "new lane still closed", int'(clk_o), 0);
        arm_gap($realtime);
        dead1 = 1'b1;
        #(20 * TCLK0_NS);
        gap_check("R8", TCLK0_NS);
        follow(0, 6, "R8");
        run1 = 1'b1;
        #(8 * TCLK1_NS);
        dead1 = 1'b0;
        #(10 * TCLK1_NS);
    endtask

    // R9: flag on the unselected input.
    task automatic t_unselected_dead;
        @(negedge clk1);
        #1 run1 = 1'b0;
        dead1 = 1'b1;
        follow(0, 8, "R9");
        run1 = 1'b1;
        #(8 * TCLK1_NS);
        dead1 = 1'b0;
        follow(0, 4, "R9");
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_switch(1);
        t_switch(0);
        t_dead_selected();
        t_old_dead_switch();
        t_switch_before_flag();
        t_unselected_dead();
        check(short_hi == 0, "R3", "short high pulses", short_hi, 0);
        check(short_lo == 0, "R3", "short low pulses", short_lo, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule